// File: doc/BRIEF.md
# Speculative and Committed Integer Register File with Window Restore

This block holds the integer registers of a core whose register set is organised in overlapping windows. It keeps two copies. The working copy serves every operand read and takes each result the moment the execute stages produce it, whether or not that result will later commit. The committed copy stores the registers of all eight windows plus the shared globals. It is written only from the final pipeline stage, once no exception can still cancel the instruction.

When the pipeline must discard speculative results, the repair strobe starts a bulk refill. The current window's registers are copied from the committed copy into the working copy, eight registers per cycle. A window switch uses the same copy path, loading the registers of the newly selected window. While a refill is running, the busy output is high, reads return zero and speculative writes are dropped. A commit that arrives during or just before a refill still ends up in the refilled working copy.

Top module: `spec_commit_rf`

## Requirements
- R1: A speculative write to a nonzero register, made while busy is low, is returned by both read ports from the next cycle on. Reads come only from the working copy.
- R2: Register 0 reads as zero. Speculative and commit writes to register 0 have no effect.
- R3: A repair strobe makes busy high for exactly the four cycles after the strobe cycle. After that, every working register equals the committed value of the current window, and uncommitted speculative writes are gone.
- R4: While busy is high, both read ports return zero and speculative writes are ignored.
- R5: A commit write, given with a window number and a register number, updates only the committed copy. A working register that is not being refilled keeps its speculative value.
- R6: Register numbers are mapped as follows. 0..7 are globals shared by all windows. 8..15 are outs. 16..23 are locals. 24..31 are ins. Out k of window w is the same storage as in k of window (w+1) mod 8. A window-change request loads the new window into the working copy, with the same busy timing as R3.
- R7: When a commit write and a repair strobe occur in the same cycle, the refilled working copy contains the committed value.
- R8: A commit write made while busy is high, to a register that aliases the window being refilled, is visible in the working copy after busy falls. This holds even when that register's group has already been copied.
- R9: When a window change and a repair occur in the same cycle, the window change takes effect. A request made while busy is high restarts the four-cycle copy from the first group.
- R10: After reset, busy is low, the window is 0 and every register in both copies reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_addr | input | 5 | Read port 0 register number |
| rd0_data | output | 64 | Read port 0 data from the working copy |
| rd1_addr | input | 5 | Read port 1 register number |
| rd1_data | output | 64 | Read port 1 data from the working copy |
| spec_we | input | 1 | Speculative write enable |
| spec_addr | input | 5 | Speculative write register number |
| spec_data | input | 64 | Speculative write data |
| cmt_we | input | 1 | Commit write enable |
| cmt_win | input | 3 | Window the committing instruction ran in |
| cmt_addr | input | 5 | Commit register number |
| cmt_data | input | 64 | Commit write data |
| repair | input | 1 | Restore the working copy of the current window |
| win_req | input | 1 | Switch to a new window |
| win_new | input | 3 | Window number for a switch |
| busy | output | 1 | Bulk copy in progress |

## Verification
The risky overlap is a commit write arriving close to a bulk copy. The bench drives a commit in the same cycle as the repair strobe, and later a commit to an already-copied global in the last copy cycle. In both cases it reads the register after busy falls and expects the committed value rather than the stale or speculative one. It also places a window request on the same cycle as a repair, and a second request in the middle of a copy. It judges which window was loaded by reading registers whose committed values differ between windows, and by counting the busy cycles.

// File: rtl/scrf_pkg.sv
package scrf_pkg;
    localparam int unsigned XLEN   = 64;
    localparam int unsigned NWIN   = 8;
    localparam int unsigned GRP    = 8;
    localparam int unsigned NGRPS  = 4;
    localparam int unsigned NWORK  = GRP * NGRPS;
    localparam int unsigned NARCH  = GRP + NWIN * 2 * GRP;
    localparam int unsigned WW     = $clog2(NWIN);
    localparam int unsigned RW     = $clog2(NWORK);
    localparam int unsigned AW     = $clog2(NARCH);
    localparam int unsigned GW     = $clog2(NGRPS);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [WW-1:0]   win_t;
    typedef logic [RW-1:0]   reg_t;
    typedef logic [AW-1:0]   aidx_t;
    typedef logic [GW-1:0]   grp_t;

    // Committed-copy slot of a register as seen from window w.
    // Layout: globals first, then per window its locals followed by its ins.
    // Outs of w live in the ins of the next window.
    function automatic aidx_t arch_of(win_t w, reg_t r);
        int unsigned g;
        int unsigned off;
        int unsigned base;
        win_t        wn;
        g    = 32'(r) / GRP;
        off  = 32'(r) % GRP;
        wn   = w + 1'b1;
        case (g)
            0:       base = 0;
            1:       base = GRP + 32'(wn) * 2 * GRP + GRP;
            2:       base = GRP + 32'(w) * 2 * GRP;
            default: base = GRP + 32'(w) * 2 * GRP + GRP;
        endcase
        return aidx_t'(base + off);
    endfunction
endpackage

// File: rtl/scrf_seq.sv
module scrf_seq
    import scrf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic repair,
    input  logic win_req,
    input  win_t win_new,
    output logic busy,
    output grp_t grp,
    output win_t cur_win
);
    typedef struct packed {
        logic busy;
        grp_t grp;
        win_t win;
    } seq_t;

    localparam grp_t LAST = grp_t'(NGRPS - 1);

    seq_t q, d;

    always_comb begin
        d = q;
        if (win_req) begin
            d.busy = 1'b1;
            d.grp  = '0;
            d.win  = win_new;
        end else if (repair) begin
            d.busy = 1'b1;
            d.grp  = '0;
        end else if (q.busy) begin
            if (q.grp == LAST) begin
                d.busy = 1'b0;
                d.grp  = '0;
            end else begin
                d.grp = q.grp + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign grp     = q.grp;
    assign cur_win = q.win;

    assert_copy_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (repair || win_req) |=> (q.busy && q.grp == '0));
    assert_copy_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.grp != LAST && !repair && !win_req) |=> q.busy);
    assert_copy_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.grp == LAST && !repair && !win_req) |=> !q.busy);
    assert_window_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        win_req |=> (q.win == $past(win_new)));
    assert_window_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !win_req |=> $stable(q.win));
endmodule

// File: rtl/scrf_arch.sv
module scrf_arch
    import scrf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmt_we,
    input  win_t             cmt_win,
    input  reg_t             cmt_addr,
    input  word_t            cmt_data,
    input  win_t             rd_win,
    input  grp_t             rd_grp,
    output word_t [GRP-1:0]  grp_data
);
    typedef struct packed {
        word_t [NARCH-1:0] r;
    } arch_t;

    arch_t q, d;

    always_comb begin
        d = q;
        if (cmt_we && cmt_addr != '0) begin
            d.r[arch_of(cmt_win, cmt_addr)] = cmt_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar k = 0; k < int'(GRP); k++) begin : g_rd
        assign grp_data[k] = q.r[arch_of(rd_win, reg_t'(32'(rd_grp) * GRP + 32'(k)))];
    end

    assert_commit_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_we && cmt_addr != '0) |=>
        (q.r[arch_of($past(cmt_win), $past(cmt_addr))] == $past(cmt_data)));
    assert_commit_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_we && cmt_addr == '0) |=> $stable(q.r[0]));
endmodule

// File: rtl/scrf_work.sv
module scrf_work
    import scrf_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            busy,
    input  grp_t            grp,
    input  win_t            cur_win,
    input  word_t [GRP-1:0] grp_data,
    input  logic            spec_we,
    input  reg_t            spec_addr,
    input  word_t           spec_data,
    input  logic            cmt_we,
    input  win_t            cmt_win,
    input  reg_t            cmt_addr,
    input  word_t           cmt_data,
    input  reg_t            rd0_addr,
    output word_t           rd0_data,
    input  reg_t            rd1_addr,
    output word_t           rd1_data
);
    typedef struct packed {
        word_t [NWORK-1:0] r;
    } work_t;

    work_t q, d;
    aidx_t cmt_slot;

    assign cmt_slot = arch_of(cmt_win, cmt_addr);

    always_comb begin
        d = q;
        if (busy) begin
            // Refill one group of the window being loaded.
            for (int k = 0; k < int'(GRP); k++) begin
                d.r[32'(grp) * GRP + 32'(k)] = grp_data[k];
            end
            // A commit during the refill also lands in any working register
            // that aliases its slot, so already-copied groups stay current.
            if (cmt_we && cmt_addr != '0) begin
                for (int i = 1; i < int'(NWORK); i++) begin
                    if (arch_of(cur_win, reg_t'(i)) == cmt_slot) begin
                        d.r[i] = cmt_data;
                    end
                end
            end
        end else if (spec_we && spec_addr != '0) begin
            d.r[spec_addr] = spec_data;
        end
        d.r[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd0_data = (busy || rd0_addr == '0) ? '0 : q.r[rd0_addr];
    assign rd1_data = (busy || rd1_addr == '0) ? '0 : q.r[rd1_addr];

    assert_spec_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_we && !busy && spec_addr != '0) |=>
        (q.r[$past(spec_addr)] == $past(spec_data)));
    assert_spec_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && grp == '0 && spec_we && spec_addr >= reg_t'(2 * GRP) && !cmt_we) |=>
        $stable(q.r[$past(spec_addr)]));
endmodule

// File: rtl/spec_commit_rf.sv
module spec_commit_rf
    import scrf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  rd0_addr,
    output logic [63:0] rd0_data,
    input  logic [4:0]  rd1_addr,
    output logic [63:0] rd1_data,
    input  logic        spec_we,
    input  logic [4:0]  spec_addr,
    input  logic [63:0] spec_data,
    input  logic        cmt_we,
    input  logic [2:0]  cmt_win,
    input  logic [4:0]  cmt_addr,
    input  logic [63:0] cmt_data,
    input  logic        repair,
    input  logic        win_req,
    input  logic [2:0]  win_new,
    output logic        busy
);
    grp_t            grp;
    win_t            cur_win;
    word_t [GRP-1:0] grp_data;

    scrf_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .repair  (repair),
        .win_req (win_req),
        .win_new (win_new),
        .busy    (busy),
        .grp     (grp),
        .cur_win (cur_win)
    );

    scrf_arch u_arch (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmt_we   (cmt_we),
        .cmt_win  (cmt_win),
        .cmt_addr (cmt_addr),
        .cmt_data (cmt_data),
        .rd_win   (cur_win),
        .rd_grp   (grp),
        .grp_data (grp_data)
    );

    scrf_work u_work (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .grp       (grp),
        .cur_win   (cur_win),
        .grp_data  (grp_data),
        .spec_we   (spec_we),
        .spec_addr (spec_addr),
        .spec_data (spec_data),
        .cmt_we    (cmt_we),
        .cmt_win   (cmt_win),
        .cmt_addr  (cmt_addr),
        .cmt_data  (cmt_data),
        .rd0_addr  (rd0_addr),
        .rd0_data  (rd0_data),
        .rd1_addr  (rd1_addr),
        .rd1_data  (rd1_data)
    );
endmodule

// File: tb/spec_commit_rf_tb.sv
module spec_commit_rf_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [4:0]  wa;
        logic [63:0] wd;
        logic [4:0]  ra;
        logic [63:0] ex;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{5'd5,  64'h11, 5'd5,  64'h11},
        '{5'd0,  64'hFF, 5'd0,  64'h0},
        '{5'd20, 64'h22, 5'd20, 64'h22},
        '{5'd31, 64'h33, 5'd5,  64'h11},
        '{5'd9,  64'h44, 5'd9,  64'h44},
        '{5'd9,  64'h55, 5'd9,  64'h55},
        '{5'd1,  64'h66, 5'd20, 64'h22},
        '{5'd0,  64'h05, 5'd31, 64'h33}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd0_addr = '0, rd1_addr = '0, spec_addr = '0, cmt_addr = '0;
    logic [63:0] rd0_data, rd1_data, spec_data = '0, cmt_data = '0;
    logic        spec_we = 1'b0, cmt_we = 1'b0, repair = 1'b0, win_req = 1'b0;
    logic [2:0]  cmt_win = '0, win_new = '0;
    logic        busy;
    int          nchk = 0;
    int          nerr = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spec_commit_rf u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .spec_we(spec_we), .spec_addr(spec_addr), .spec_data(spec_data),
        .cmt_we(cmt_we), .cmt_win(cmt_win), .cmt_addr(cmt_addr), .cmt_data(cmt_data),
        .repair(repair), .win_req(win_req), .win_new(win_new), .busy(busy)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        spec_we = 1'b0; cmt_we = 1'b0; repair = 1'b0; win_req = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [63:0] v);
        rd0_addr = a;
        #1;
        v = rd0_data;
    endtask

    task automatic commit(input logic [2:0] w, input logic [4:0] r, input logic [63:0] v);
        cmt_we = 1'b1; cmt_win = w; cmt_addr = r; cmt_data = v;
        step();
    endtask

    task automatic wait_copy(output int n);
        n = 0;
        while (busy && n < 10) begin
            step();
            n++;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        nchk++; nerr++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [63:0] v;
        int          n;
        step(); step();
        rst_n = 1'b1;
        step();
        // R10: reset state
        chk("R10 busy", {63'd0, busy}, 64'd0);
        rd(5'd5, v);  chk("R10 r5", v, 64'd0);

        // Table walk: speculative writes and reads (R1, R2)
        foreach (VECS[i]) begin
            spec_we = 1'b1; spec_addr = VECS[i].wa; spec_data = VECS[i].wd;
            step();
            rd1_addr = VECS[i].wa;
            rd(VECS[i].ra, v);
            chk((VECS[i].ra == 5'd0) ? "R2 rd0" : "R1 rd0", v, VECS[i].ex);
            chk((VECS[i].wa == 5'd0) ? "R2 rd1" : "R1 rd1", rd1_data,
                (VECS[i].wa == 5'd0) ? 64'd0 : VECS[i].wd);
        end

        // R5: commit does not touch working copy
        commit(3'd0, 5'd9, 64'h1234);
        rd(5'd9, v); chk("R5 r9 keeps spec", v, 64'h55);

        // R7: commit and repair in the same cycle; R4 during copy
        cmt_we = 1'b1; cmt_win = 3'd0; cmt_addr = 5'd5; cmt_data = 64'hAA;
        repair = 1'b1;
        step();
        chk("R3 busy up", {63'd0, busy}, 64'd1);
        rd(5'd5, v); chk("R4 read zero while busy", v, 64'd0);
        spec_we = 1'b1; spec_addr = 5'd16; spec_data = 64'h99;
        wait_copy(n);
        chk("R3 busy cycles", 64'(n), 64'd4);
        rd(5'd5,  v); chk("R7 r5", v, 64'hAA);
        rd(5'd9,  v); chk("R5 r9 after repair", v, 64'h1234);
        rd(5'd20, v); chk("R3 r20 discarded", v, 64'd0);
        rd(5'd1,  v); chk("R3 r1 discarded", v, 64'd0);
        rd(5'd16, v); chk("R4 spec write ignored", v, 64'd0);

        // R6: window change and aliasing
        commit(3'd0, 5'd10, 64'hB0B0);
        commit(3'd1, 5'd17, 64'hC1);
        commit(3'd3, 5'd1,  64'h61);
        win_req = 1'b1; win_new = 3'd1;
        step();
        wait_copy(n);
        chk("R6 busy cycles", 64'(n), 64'd4);
        rd(5'd26, v); chk("R6 in2 aliases out2 of w0", v, 64'hB0B0);
        rd(5'd17, v); chk("R6 local1 of w1", v, 64'hC1);
        rd(5'd1,  v); chk("R6 global shared", v, 64'h61);
        rd(5'd10, v); chk("R6 out2 of w1", v, 64'd0);
        rd(5'd5,  v); chk("R6 global r5", v, 64'hAA);

        // R6: wrap from window 7 to window 0
        commit(3'd0, 5'd24, 64'hD0);
        win_req = 1'b1; win_new = 3'd7;
        step();
        wait_copy(n);
        rd(5'd8, v); chk("R6 out0 of w7 wraps", v, 64'hD0);

        // R8: commit in the last copy cycle to an already copied global
        repair = 1'b1;
        step(); step(); step(); step();
        cmt_we = 1'b1; cmt_win = 3'd7; cmt_addr = 5'd3; cmt_data = 64'hE7E7;
        step();
        chk("R8 busy done", {63'd0, busy}, 64'd0);
        rd(5'd3, v); chk("R8 forwarded commit", v, 64'hE7E7);

        // R9: window change beats repair in the same cycle
        commit(3'd2, 5'd16, 64'h2222);
        win_req = 1'b1; win_new = 3'd2; repair = 1'b1;
        step();
        wait_copy(n);
        rd(5'd16, v); chk("R9 window 2 loaded", v, 64'h2222);

        // R9: request during copy restarts it
        repair = 1'b1;
        step(); step();
        win_req = 1'b1; win_new = 3'd1;
        step();
        wait_copy(n);
        chk("R9 restart busy cycles", 64'(n), 64'd4);
        rd(5'd17, v); chk("R9 window 1 loaded", v, 64'hC1);

        // R2: commit to register 0 ignored
        commit(3'd1, 5'd0, 64'h77);
        repair = 1'b1;
        step();
        wait_copy(n);
        rd1_addr = 5'd0;
        rd(5'd0, v); chk("R2 commit r0", v, 64'd0);
        chk("R2 rd1 r0", rd1_data, 64'd0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule